// File: doc/BRIEF.md
# Display Register Read Engine

This block runs one register read on a four-wire serial display link that has a separate data/command select line. A request carries an opcode and a byte count. The engine first checks that the opcode is a known read command and that the count is legal. It then lowers chip select and drives the select line low. It shifts the opcode out most significant bit first and clocks in the response at a reduced read clock. Each assembled response byte comes out on a byte stream, and a last flag marks the final byte.

Two commands, the identity read (0x04) and the status read (0x09), return one dummy clock ahead of the data. For these two commands the engine clocks one extra response byte. It realigns the stream so that corrected byte i equals (raw[i] << 1) | raw[i+1][7]. When a power-mode read (0x0A) completes, the engine also judges whether the panel is on.

Top module: `dspr_read_engine`

## Requirements
- R1: Only opcodes in the read set are accepted: 0x04, 0x06, 0x07, 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0D, 0x0E, 0x0F, 0x2E, 0x3E, 0x45, 0x52, 0x54, 0x56, 0x5F, 0xA1, 0xA8. An idle request with any other opcode raises `err` for exactly one cycle, one clock after the request edge, and chip select stays high.
- R2: An idle request with a byte count of zero raises `err` in the same way and starts no transfer.
- R3: For opcodes 0x04 and 0x09 the count must be 3 or 4. Any other count raises `err`, and counts 3 and 4 are accepted.
- R4: Once a transfer is accepted, `lcd_cs_n` stays low from the opcode through the last clock. `lcd_dc` is low whenever `lcd_cs_n` is low. The opcode is sent MSB first on `lcd_mosi` and is valid on rising `lcd_sck` edges.
- R5: The read clock has high and low phases of HALF system cycles each. HALF = ceil(SYS_HZ / (2 * min(2 MHz, LINK_MAX_HZ / 2))), which is 13 at the defaults.
- R6: A transfer has 8 + 8*len rising clock edges. For 0x04 and 0x09 it has 8 + 8*(len+1).
- R7: For normal reads, response bits sampled on rising edges after the opcode form bytes MSB first, and each byte appears on `rd_data` with a one-cycle `rd_valid`.
- R8: For 0x04 and 0x09 the first response bit is discarded, so byte i = (raw[i]<<1) | raw[i+1][7].
- R9: Exactly len bytes are delivered, and `rd_last` is high only together with the final byte.
- R10: `panel_on_valid` is 0 from reset until a 0x0A read completes. At that point `panel_on` becomes 1 if the first response byte ANDed with 0x7C equals 0x1C, meaning bits 2, 3 and 4 are set and bits 5 and 6 are clear, with bits 0, 1 and 7 ignored. Otherwise it becomes 0.
- R11: A request made while `busy` is high is ignored. It raises no `err`, does not disturb the running transfer and starts no later transfer.
- R12: After reset `lcd_cs_n`=1, `lcd_sck`=0, `lcd_dc`=1, and `busy`, `err`, `rd_valid` and `panel_on_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request strobe |
| req_op | input | 8 | Read opcode |
| req_len | input | LEN_W | Requested response byte count |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | One-cycle pulse on a rejected request |
| rd_valid | output | 1 | Response byte strobe |
| rd_data | output | 8 | Response byte (realigned where needed) |
| rd_last | output | 1 | Marks the final response byte |
| panel_on | output | 1 | Panel judged on by the last power-mode read |
| panel_on_valid | output | 1 | A power-mode read has completed |
| lcd_sck | output | 1 | Link clock, idle low |
| lcd_cs_n | output | 1 | Link chip select, active low |
| lcd_dc | output | 1 | Data/command select, low during reads |
| lcd_mosi | output | 1 | Opcode serial out |
| lcd_miso | input | 1 | Response serial in |

## Verification
A rejected request shows `err` on the first clock after the request edge and drops it one clock later. The bench samples `err` on exactly those two falling edges. Each response byte appears one system cycle after the rising link edge that completes it, and `rd_last` comes with the final byte. Since that edge falls a computed number of read-clock periods into the transfer, a monitor compares each `rd_valid` against a queue of expected bytes in order, instead of waiting for a fixed cycle. The panel flags change one cycle after `rd_last`, and the bench reads them only after chip select has risen. The link model on the bench counts rising edges, records the opcode and the select level, and measures every high phase against 13 cycles.

// File: rtl/dspr_pkg.sv
package dspr_pkg;

   typedef enum logic [0:0] {ST_IDLE, ST_XFER} dspr_state_t;

   localparam logic [7:0] OP_IDENT = 8'h04;
   localparam logic [7:0] OP_STAT  = 8'h09;
   localparam logic [7:0] OP_PWR   = 8'h0A;

   function automatic logic is_read_op(input logic [7:0] op);
      case (op)
         8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C,
         8'h0D, 8'h0E, 8'h0F, 8'h2E, 8'h3E, 8'h45, 8'h52, 8'h54,
         8'h56, 8'h5F, 8'hA1, 8'hA8: return 1'b1;
         default:                    return 1'b0;
      endcase
   endfunction

   function automatic logic has_lead_dummy(input logic [7:0] op);
      return (op == OP_IDENT) || (op == OP_STAT);
   endfunction

   // system cycles per half period of the read clock, rounded up
   function automatic int unsigned half_period(input int unsigned sys_hz,
                                               input int unsigned link_hz,
                                               input int unsigned cap_hz);
      int unsigned rd_hz;
      rd_hz = ((link_hz / 2) < cap_hz) ? (link_hz / 2) : cap_hz;
      return (sys_hz + 2 * rd_hz - 1) / (2 * rd_hz);
   endfunction

endpackage

// File: rtl/dspr_sck_tick.sv
module dspr_sck_tick #(
   parameter int unsigned HALF = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

   if (HALF < 1) begin : g_bad_half
      $error("dspr_sck_tick: HALF must be at least 1");
   end

   logic [CW-1:0] cnt;

   assign tick = en && (cnt == CW'(HALF - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/dspr_rx_align.sv
module dspr_rx_align #(
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             skip_first,
   input  logic [LEN_W-1:0] len,
   input  logic             sample,
   input  logic             din,
   output logic             vld,
   output logic [7:0]       dout,
   output logic             last
);
   logic             skip;
   logic [6:0]       sh;
   logic [2:0]       bcnt;
   logic [LEN_W-1:0] nb;
   logic [LEN_W-1:0] len_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         skip  <= 1'b0;
         sh    <= '0;
         bcnt  <= '0;
         nb    <= '0;
         len_q <= '0;
         vld   <= 1'b0;
         dout  <= '0;
         last  <= 1'b0;
      end else begin
         vld  <= 1'b0;
         last <= 1'b0;
         if (clear) begin
            skip  <= skip_first;
            bcnt  <= '0;
            nb    <= '0;
            len_q <= len;
         end else if (sample) begin
            if (skip) begin
               skip <= 1'b0;            // drop the leading dummy bit
            end else if (nb != len_q) begin
               sh   <= {sh[5:0], din};
               bcnt <= bcnt + 1'b1;
               if (bcnt == 3'd7) begin
                  vld  <= 1'b1;
                  dout <= {sh, din};
                  last <= (LEN_W'(nb + 1'b1) == len_q);
                  nb   <= nb + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/dspr_pwr_judge.sv
module dspr_pwr_judge (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       start_is_pwr,
   input  logic       vld,
   input  logic [7:0] byte_in,
   input  logic       last,
   output logic       on,
   output logic       on_vld
);
   localparam logic [7:0] CARE = 8'h7C;
   localparam logic [7:0] WANT = 8'h1C;

   logic       track;
   logic       first_seen;
   logic [7:0] cap;
   logic [7:0] cand;

   assign cand = first_seen ? cap : byte_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         track      <= 1'b0;
         first_seen <= 1'b0;
         cap        <= '0;
         on         <= 1'b0;
         on_vld     <= 1'b0;
      end else if (start) begin
         track      <= start_is_pwr;
         first_seen <= 1'b0;
      end else if (vld) begin
         if (!first_seen) begin
            cap        <= byte_in;
            first_seen <= 1'b1;
         end
         if (last && track) begin
            on     <= ((cand & CARE) == WANT);
            on_vld <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/dspr_read_engine.sv
module dspr_read_engine
   import dspr_pkg::*;
#(
   parameter int unsigned SYS_HZ      = 50_000_000,
   parameter int unsigned LINK_MAX_HZ = 10_000_000,
   parameter int unsigned READ_CAP_HZ = 2_000_000,
   parameter int          LEN_W       = 4,
   parameter bit          DUMMY_FIX   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [7:0]       req_op,
   input  logic [LEN_W-1:0] req_len,
   output logic             busy,
   output logic             err,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   output logic             rd_last,
   output logic             panel_on,
   output logic             panel_on_valid,
   output logic             lcd_sck,
   output logic             lcd_cs_n,
   output logic             lcd_dc,
   output logic             lcd_mosi,
   input  logic             lcd_miso
);
   localparam int unsigned HALF   = half_period(SYS_HZ, LINK_MAX_HZ, READ_CAP_HZ);
   localparam int          EDGE_W = $clog2(8 * ((1 << LEN_W) + 1) + 1);

   if (LEN_W < 3) begin : g_bad_len
      $error("dspr_read_engine: LEN_W must allow counts of 3 and 4");
   end
   if (READ_CAP_HZ == 0 || LINK_MAX_HZ < 2) begin : g_bad_clk
      $error("dspr_read_engine: clock limits must be nonzero");
   end

   dspr_state_t       st;
   logic [7:0]        op_sh;
   logic [EDGE_W-1:0] edge_n;
   logic [EDGE_W-1:0] edge_total;
   logic              tick;
   logic              req_lead;
   logic              id_stat;
   logic              len_ok;
   logic              req_ok;
   logic              accept;
   logic [LEN_W:0]    req_nbytes;
   logic              sample;

   if (DUMMY_FIX) begin : g_fix
      assign req_lead = has_lead_dummy(req_op);
   end else begin : g_nofix
      assign req_lead = 1'b0;
   end

   assign id_stat    = has_lead_dummy(req_op);
   assign len_ok     = (req_len != '0) &&
                       (!id_stat || req_len == LEN_W'(3) || req_len == LEN_W'(4));
   assign req_ok     = is_read_op(req_op) && len_ok;
   assign accept     = (st == ST_IDLE) && req_valid && req_ok;
   assign req_nbytes = {1'b0, req_len} + {{LEN_W{1'b0}}, req_lead};
   assign sample     = tick && !lcd_sck && (edge_n >= EDGE_W'(8));
   assign busy       = (st == ST_XFER);

   dspr_sck_tick #(.HALF(HALF)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (st == ST_XFER),
      .tick (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         op_sh      <= '0;
         edge_n     <= '0;
         edge_total <= '0;
         err        <= 1'b0;
         lcd_sck    <= 1'b0;
         lcd_cs_n   <= 1'b1;
         lcd_dc     <= 1'b1;
         lcd_mosi   <= 1'b0;
      end else begin
         err <= (st == ST_IDLE) && req_valid && !req_ok;
         case (st)
            ST_IDLE: begin
               if (accept) begin
                  st         <= ST_XFER;
                  lcd_cs_n   <= 1'b0;
                  lcd_dc     <= 1'b0;
                  lcd_mosi   <= req_op[7];
                  op_sh      <= req_op;
                  edge_n     <= '0;
                  edge_total <= EDGE_W'(8) + (EDGE_W'(req_nbytes) << 3);
               end
            end
            ST_XFER: begin
               if (tick) begin
                  if (!lcd_sck) begin
                     lcd_sck <= 1'b1;
                     edge_n  <= edge_n + 1'b1;
                  end else begin
                     lcd_sck <= 1'b0;
                     if (edge_n == edge_total) begin
                        st       <= ST_IDLE;
                        lcd_cs_n <= 1'b1;
                        lcd_dc   <= 1'b1;
                        lcd_mosi <= 1'b0;
                     end else begin
                        op_sh    <= {op_sh[6:0], 1'b0};
                        lcd_mosi <= op_sh[6];
                     end
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   dspr_rx_align #(.LEN_W(LEN_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (accept),
      .skip_first(req_lead),
      .len       (req_len),
      .sample    (sample),
      .din       (lcd_miso),
      .vld       (rd_valid),
      .dout      (rd_data),
      .last      (rd_last)
   );

   dspr_pwr_judge u_pwr (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (accept),
      .start_is_pwr(req_op == OP_PWR),
      .vld         (rd_valid),
      .byte_in     (rd_data),
      .last        (rd_last),
      .on          (panel_on),
      .on_vld      (panel_on_valid)
   );
endmodule

// File: rtl/dspr_read_engine_chk.sv
module dspr_read_engine_chk #(
   parameter int unsigned HALF = 13
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic busy,
   input logic err,
   input logic rd_valid,
   input logic rd_last,
   input logic panel_on,
   input logic panel_on_valid,
   input logic lcd_sck,
   input logic lcd_cs_n,
   input logic lcd_dc
);
   logic [15:0] hi_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)       hi_cnt <= '0;
      else if (lcd_sck) hi_cnt <= hi_cnt + 1'b1;
      else              hi_cnt <= '0;
   end

   p_sck_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_sck |-> !lcd_cs_n);
   p_dc_low_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !lcd_cs_n |-> !lcd_dc);
   p_sck_high_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lcd_sck) |-> (hi_cnt == 16'(HALF)));
   p_err_no_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> lcd_cs_n);
   p_byte_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !lcd_cs_n);
   p_last_with_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |-> rd_valid);
   p_on_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      panel_on |-> panel_on_valid);
   p_ignore_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |=> !err);
endmodule

bind dspr_read_engine dspr_read_engine_chk
   #(.HALF(dspr_pkg::half_period(SYS_HZ, LINK_MAX_HZ, READ_CAP_HZ))) u_chk (.*);

// File: tb/dspr_read_engine_bench.sv
module dspr_read_engine_bench;
   localparam int LEN_W    = 4;
   localparam int EXP_HALF = (50_000_000 + 4_000_000 - 1) / 4_000_000; // R5

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic [7:0]       req_op = '0;
   logic [LEN_W-1:0] req_len = '0;
   logic             busy, err, rd_valid, rd_last, panel_on, panel_on_valid;
   logic [7:0]       rd_data;
   logic             lcd_sck, lcd_cs_n, lcd_dc, lcd_mosi;
   logic             lcd_miso = 1'b0;

   always #10 clk = ~clk;

   dspr_read_engine u_dspr_read_engine (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_len(req_len), .busy(busy), .err(err), .rd_valid(rd_valid),
      .rd_data(rd_data), .rd_last(rd_last), .panel_on(panel_on),
      .panel_on_valid(panel_on_valid), .lcd_sck(lcd_sck), .lcd_cs_n(lcd_cs_n),
      .lcd_dc(lcd_dc), .lcd_mosi(lcd_mosi), .lcd_miso(lcd_miso)
   );

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", what, act, exp);
      end
   endtask

   // ---------------- link device model ----------------
   logic       dev_bits [0:199];
   int         dev_cnt = 0;
   logic [7:0] dev_op  = '0;
   int         dc_bad  = 0;

   always @(negedge lcd_cs_n) begin
      dev_cnt = 0;
      dev_op  = '0;
   end
   always @(posedge lcd_sck) begin
      if (dev_cnt < 8) dev_op = {dev_op[6:0], lcd_mosi};
      if (lcd_dc !== 1'b0 || lcd_cs_n !== 1'b0) dc_bad++;
      dev_cnt++;
   end
   always @(negedge lcd_sck) begin
      if (dev_cnt >= 8 && dev_cnt - 8 < 200) lcd_miso <= dev_bits[dev_cnt-8];
   end

   // ---------------- read clock width monitor ----------------
   int hi = 0;
   int wid_bad = 0;
   int wid_seen = 0;
   always @(negedge clk) begin
      if (lcd_sck === 1'b1) hi++;
      else if (hi != 0) begin
         if (hi != EXP_HALF) wid_bad++;
         wid_seen++;
         hi = 0;
      end
   end

   // ---------------- scoreboard ----------------
   logic [8:0] sb_q[$];
   always @(negedge clk) begin
      if (rst_n && rd_valid === 1'b1) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R9 unexpected byte", int'(rd_data), 0);
         end else begin
            logic [8:0] e;
            e = sb_q.pop_front();
            chk(rd_data === e[7:0], "R7/R8 byte value", int'(rd_data), int'(e[7:0]));
            chk(rd_last === e[8], "R9 last flag", int'(rd_last), int'(e[8]));
         end
      end
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         bad++;
         $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- driver tasks ----------------
   logic [7:0] data_b [0:15];

   task automatic load_stream(input bit lead, input int n);
      int pos;
      for (int i = 0; i < 200; i++) dev_bits[i] = 1'b0;
      pos = 0;
      if (lead) begin
         dev_bits[0] = 1'b1;
         pos = 1;
      end
      for (int b = 0; b < n; b++)
         for (int k = 7; k >= 0; k--) begin
            dev_bits[pos] = data_b[b][k];
            pos++;
         end
   endtask

   task automatic pulse_req(input logic [7:0] op, input int len);
      @(negedge clk);
      req_valid = 1'b1;
      req_op    = op;
      req_len   = LEN_W'(len);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_err(input logic [7:0] op, input int len, input string tag);
      pulse_req(op, len);
      chk(err === 1'b1, {tag, " err pulse"}, int'(err), 1);
      chk(lcd_cs_n === 1'b1, {tag, " no frame"}, int'(lcd_cs_n), 1);
      @(negedge clk);
      chk(err === 1'b0, {tag, " err one cycle"}, int'(err), 0);
   endtask

   task automatic start_read(input logic [7:0] op, input int len, input bit lead);
      load_stream(lead, len);
      for (int i = 0; i < len; i++) sb_q.push_back({(i == len - 1), data_b[i]});
      dc_bad   = 0;
      wid_bad  = 0;
      wid_seen = 0;
      pulse_req(op, len);
      chk(lcd_cs_n === 1'b0 && busy === 1'b1, "R4 frame opened", int'(lcd_cs_n), 0);
   endtask

   task automatic finish_read(input logic [7:0] op, input int len, input bit lead);
      int exp_edges;
      while (lcd_cs_n !== 1'b1) @(negedge clk);
      @(negedge clk);
      exp_edges = 8 + 8 * (len + (lead ? 1 : 0));
      chk(dev_cnt == exp_edges, "R6 rising edge count", dev_cnt, exp_edges);
      chk(dev_op === op, "R4 opcode MSB first", int'(dev_op), int'(op));
      chk(dc_bad == 0, "R4 dc low and cs low at every edge", dc_bad, 0);
      chk(wid_bad == 0 && wid_seen > 0, "R5 clock high width", wid_bad, 0);
      chk(sb_q.size() == 0, "R9 byte count", sb_q.size(), 0);
      sb_q.delete();
   endtask

   task automatic do_read(input logic [7:0] op, input int len, input bit lead);
      start_read(op, len, lead);
      finish_read(op, len, lead);
   endtask

   // ---------------- sequence ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk(lcd_cs_n === 1'b1, "R12 cs idle", int'(lcd_cs_n), 1);
      chk(lcd_sck === 1'b0, "R12 sck idle", int'(lcd_sck), 0);
      chk(lcd_dc === 1'b1, "R12 dc idle", int'(lcd_dc), 1);
      chk(busy === 1'b0 && err === 1'b0 && rd_valid === 1'b0, "R12 flags idle", int'(busy), 0);
      chk(panel_on_valid === 1'b0, "R12 panel flag idle", int'(panel_on_valid), 0);

      expect_err(8'h2C, 1, "R1 opcode 0x2C");
      expect_err(8'h00, 2, "R1 opcode 0x00");
      expect_err(8'h0A, 0, "R2 zero length");
      expect_err(8'h04, 2, "R3 ident len 2");
      expect_err(8'h09, 5, "R3 status len 5");

      // R7 normal two-byte read; R10 flag must stay invalid
      data_b[0] = 8'hA5; data_b[1] = 8'h3C;
      do_read(8'h0B, 2, 1'b0);
      chk(panel_on_valid === 1'b0, "R10 invalid before power read", int'(panel_on_valid), 0);

      // R8 ident read with dummy clock, len 3
      data_b[0] = 8'h5A; data_b[1] = 8'hC3; data_b[2] = 8'h81;
      do_read(8'h04, 3, 1'b1);

      // R8 status read with dummy clock, len 4
      data_b[0] = 8'hFE; data_b[1] = 8'h01; data_b[2] = 8'h80; data_b[3] = 8'h7F;
      do_read(8'h09, 4, 1'b1);

      // R7 memory read, len 3
      data_b[0] = 8'h12; data_b[1] = 8'h34; data_b[2] = 8'hE7;
      do_read(8'h2E, 3, 1'b0);

      // R10 power mode decode
      data_b[0] = 8'h9C;
      do_read(8'h0A, 1, 1'b0);
      chk(panel_on_valid === 1'b1 && panel_on === 1'b1, "R10 0x9C judged on", int'(panel_on), 1);
      data_b[0] = 8'h18;
      do_read(8'h0A, 1, 1'b0);
      chk(panel_on === 1'b0, "R10 0x18 judged off", int'(panel_on), 0);
      data_b[0] = 8'h1F;
      do_read(8'h0A, 1, 1'b0);
      chk(panel_on === 1'b1, "R10 0x1F judged on", int'(panel_on), 1);
      data_b[0] = 8'h3C; data_b[1] = 8'h1C;
      do_read(8'h0A, 2, 1'b0);
      chk(panel_on === 1'b0, "R10 first byte 0x3C judged off", int'(panel_on), 0);

      // R11 requests while busy are ignored
      data_b[0] = 8'h66;
      start_read(8'h0B, 1, 1'b0);
      repeat (60) @(negedge clk);
      pulse_req(8'h2C, 1);
      chk(err === 1'b0, "R11 bad request while busy no err", int'(err), 0);
      repeat (60) @(negedge clk);
      pulse_req(8'h0A, 1);
      chk(err === 1'b0, "R11 good request while busy no err", int'(err), 0);
      finish_read(8'h0B, 1, 1'b0);
      repeat (40) @(negedge clk);
      chk(lcd_cs_n === 1'b1 && busy === 1'b0, "R11 no deferred transfer", int'(lcd_cs_n), 1);
      chk(panel_on === 1'b0, "R11 panel flag untouched", int'(panel_on), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule